// File: doc/BRIEF.md
# Configuration Stream Preamble Aligner

This block sits between a source of configuration image bytes and a serial configuration engine. Both sides use a valid/ready byte handshake. At the start of each image the block is in a search state. It accepts bytes and drops them until it recognises a synchronisation preamble. It then sends the preamble bytes downstream, followed by every later byte of the image up to and including the byte marked as end of image. After that it returns to the search state for the next image.

A mode input selects the preamble rule. In uncompressed mode the preamble is a run of four 0xFF bytes. In compressed mode it is a 0xFF byte followed by any byte whose upper nibble is 0x3.

While a partial match is in progress, the candidate bytes are held in a short history buffer and nothing is forwarded. When the match completes, the buffer is replayed downstream. The block reports the zero-based position of the first preamble byte within the image. If an image ends with no preamble, it raises a sticky error flag and forwards nothing.

Top module: `cfg_sync_aligner`

## Requirements
- R1: With `mode_comp`=0, the preamble is four consecutive bytes of 0xFF. Every byte before the first such run is accepted and dropped.
- R2: With `mode_comp`=1, the preamble is a 0xFF byte followed by a byte with bits [7:4] equal to 4'h3. Bits [3:0] of that second byte are ignored.
- R3: The forwarded stream starts at the first preamble byte and holds the preamble and all later bytes of the image, in their original order. `out_last` is high only on the final byte of the image.
- R4: On a match, `sync_found` pulses high for exactly one cycle. `sync_offset` then holds the zero-based index of the first preamble byte within the current image, and keeps it until the next match.
- R5: In compressed mode a 0xFF that is the last byte of an image never matches. A preamble whose second byte is the last byte of the image does match, and that byte is forwarded with `out_last` high.
- R6: If the end-of-image byte is accepted while no preamble has been found, nothing is forwarded for that image. `no_sync_err` goes high and stays high until reset.
- R7: Bytes of a partial match that is then broken are never forwarded. A byte that breaks a partial match can still begin a new match, for example FF FF FF 00 FF FF FF FF, or FF FF 3x.
- R8: While the preamble is being replayed, `in_ready` is low. A replayed byte stays stable while `out_ready` is low. After alignment, `in_ready` follows `out_ready` and bytes pass through unchanged.
- R9: After the end-of-image byte is transferred, the block searches afresh. Offsets in the next image are counted from that image's first byte.
- R10: After reset, `out_valid`=0, `in_ready`=1, `no_sync_err`=0 and `sync_found`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_comp | input | 1 | Preamble rule: 0 selects four 0xFF bytes, 1 selects 0xFF then 0x3x |
| in_valid | input | 1 | Upstream byte valid |
| in_data | input | 8 | Upstream byte |
| in_last | input | 1 | Upstream byte is the last byte of the image |
| in_ready | output | 1 | Block accepts the upstream byte |
| out_valid | output | 1 | Downstream byte valid |
| out_data | output | 8 | Downstream byte |
| out_last | output | 1 | Downstream byte is the last byte of the image |
| out_ready | input | 1 | Downstream accepts the byte |
| sync_found | output | 1 | One-cycle pulse when a preamble completes |
| sync_offset | output | OFS_W | Index of the first preamble byte in the image |
| no_sync_err | output | 1 | Sticky flag: an image ended without a preamble |

## Verification
The bench goes after overlapping runs, where a design that simply clears its counter on a mismatch would miss a preamble that begins at the breaking byte, or would report the wrong offset. It sends a compressed image whose last byte is a lone 0xFF; a design that matched on a 0xFF alone would forward that byte instead of flagging the error. It also sends a preamble that ends exactly on the last byte, which catches a design that loses `out_last` during replay. Images with an uncompressed-style preamble but the other mode selected, and the reverse, catch a design that ignores the mode. Downstream back-pressure during replay exposes replayed bytes that change or get dropped while stalled.

// File: rtl/cfg_align_pkg.sv
package cfg_align_pkg;

  localparam int unsigned HIST_DEPTH = 4;
  localparam logic [7:0]  SYNC_BYTE  = 8'hFF;
  localparam logic [3:0]  COMP_NIB   = 4'h3;

  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_REPLAY = 2'd1,
    ST_PASS   = 2'd2
  } align_state_e;

  // index of the oldest preamble byte in the history (preamble length - 1)
  function automatic logic [1:0] replay_top(input logic comp);
    return comp ? 2'd1 : 2'd3;
  endfunction

  // saturating count of consecutive 0xFF bytes seen so far
  function automatic logic [1:0] next_run(input logic [1:0] run, input logic [7:0] b);
    if (b != SYNC_BYTE) return 2'd0;
    return (run == 2'd3) ? 2'd3 : run + 2'd1;
  endfunction

  // does byte b complete a preamble given the run before it
  function automatic logic sync_hit(input logic comp, input logic [1:0] run,
                                    input logic [7:0] b);
    if (comp) return (run != 2'd0) && (b[7:4] == COMP_NIB);
    return (run == 2'd3) && (b == SYNC_BYTE);
  endfunction

endpackage

// File: rtl/cfg_align_matcher.sv
module cfg_align_matcher
  import cfg_align_pkg::*;
#(
  parameter int unsigned OFS_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        comp,
  input  logic                        take,
  input  logic [7:0]                  byte_i,
  input  logic                        last_i,
  output logic                        hit,
  output logic [OFS_W-1:0]            hit_offset,
  output logic [HIST_DEPTH-1:0][7:0]  hist
);

  logic [1:0]       run_q;
  logic [OFS_W-1:0] idx_q;

  always_comb begin
    hit        = sync_hit(comp, run_q, byte_i);
    hit_offset = idx_q - OFS_W'(replay_top(comp));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= '0;
      idx_q <= '0;
    end else if (take) begin
      if (hit || last_i) begin
        run_q <= '0;
        idx_q <= '0;
      end else begin
        run_q <= next_run(run_q, byte_i);
        idx_q <= idx_q + OFS_W'(1);
      end
    end
  end

  // newest byte in entry 0, older bytes shift toward the top
  always_ff @(posedge clk) begin
    if (!rst_n) hist[0] <= '0;
    else if (take) hist[0] <= byte_i;
  end

  for (genvar k = 1; k < HIST_DEPTH; k++) begin : g_hist
    always_ff @(posedge clk) begin
      if (!rst_n) hist[k] <= '0;
      else if (take) hist[k] <= hist[k-1];
    end
  end

endmodule

// File: rtl/cfg_align_ctrl.sv
module cfg_align_ctrl
  import cfg_align_pkg::*;
#(
  parameter int unsigned OFS_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        comp,
  input  logic                        in_valid,
  input  logic [7:0]                  in_data,
  input  logic                        in_last,
  output logic                        in_ready,
  output logic                        out_valid,
  output logic [7:0]                  out_data,
  output logic                        out_last,
  input  logic                        out_ready,
  input  logic                        hit,
  input  logic [OFS_W-1:0]            hit_offset,
  input  logic [HIST_DEPTH-1:0][7:0]  hist,
  output logic                        take,
  output logic                        sync_found,
  output logic [OFS_W-1:0]            sync_offset,
  output logic                        no_sync_err,
  output align_state_e                state
);

  logic [1:0] rep_idx_q;
  logic       last_pend_q;

  always_comb begin
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_data  = in_data;
    out_last  = 1'b0;
    unique case (state)
      ST_SEARCH: in_ready = 1'b1;
      ST_REPLAY: begin
        out_valid = 1'b1;
        out_data  = hist[rep_idx_q];
        out_last  = last_pend_q && (rep_idx_q == 2'd0);
      end
      default: begin
        in_ready  = out_ready;
        out_valid = in_valid;
        out_last  = in_last;
      end
    endcase
    take = in_valid && (state == ST_SEARCH);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_SEARCH;
      rep_idx_q   <= '0;
      last_pend_q <= 1'b0;
      sync_found  <= 1'b0;
      sync_offset <= '0;
      no_sync_err <= 1'b0;
    end else begin
      sync_found <= 1'b0;
      unique case (state)
        ST_SEARCH: if (take) begin
          if (hit) begin
            state       <= ST_REPLAY;
            rep_idx_q   <= replay_top(comp);
            last_pend_q <= in_last;
            sync_found  <= 1'b1;
            sync_offset <= hit_offset;
          end else if (in_last) begin
            no_sync_err <= 1'b1;
          end
        end
        ST_REPLAY: if (out_ready) begin
          if (rep_idx_q == 2'd0) state <= last_pend_q ? ST_SEARCH : ST_PASS;
          else rep_idx_q <= rep_idx_q - 2'd1;
        end
        default: if (in_valid && out_ready && in_last) state <= ST_SEARCH;
      endcase
    end
  end

endmodule

// File: rtl/cfg_sync_aligner.sv
module cfg_sync_aligner
  import cfg_align_pkg::*;
#(
  parameter int unsigned OFS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_comp,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             in_ready,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_last,
  input  logic             out_ready,
  output logic             sync_found,
  output logic [OFS_W-1:0] sync_offset,
  output logic             no_sync_err
);

  logic                       take;
  logic                       hit;
  logic [OFS_W-1:0]           hit_offset;
  logic [HIST_DEPTH-1:0][7:0] hist;
  align_state_e               state;

  // named events for the checker
  logic search_active, replay_active, pass_active;
  assign search_active = (state == ST_SEARCH);
  assign replay_active = (state == ST_REPLAY);
  assign pass_active   = (state == ST_PASS);

  cfg_align_matcher #(.OFS_W(OFS_W)) matcher_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .comp       (mode_comp),
    .take       (take),
    .byte_i     (in_data),
    .last_i     (in_last),
    .hit        (hit),
    .hit_offset (hit_offset),
    .hist       (hist)
  );

  cfg_align_ctrl #(.OFS_W(OFS_W)) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .comp        (mode_comp),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .in_last     (in_last),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_last    (out_last),
    .out_ready   (out_ready),
    .hit         (hit),
    .hit_offset  (hit_offset),
    .hist        (hist),
    .take        (take),
    .sync_found  (sync_found),
    .sync_offset (sync_offset),
    .no_sync_err (no_sync_err),
    .state       (state)
  );

endmodule

// File: rtl/cfg_sync_aligner_chk.sv
module cfg_sync_aligner_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       out_valid,
  input logic [7:0] out_data,
  input logic       out_last,
  input logic       out_ready,
  input logic       sync_found,
  input logic       no_sync_err,
  input logic       search_active,
  input logic       replay_active,
  input logic       pass_active
);

  AST_REPLAY_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    replay_active |-> !in_ready); // R8

  AST_REPLAY_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (replay_active && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R8

  AST_PASS_READY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    pass_active |-> (in_ready == out_ready)); // R8

  AST_SEARCH_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    search_active |-> !out_valid); // R7

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    no_sync_err |=> no_sync_err); // R6

  AST_FOUND_STARTS_FF: assert property (@(posedge clk) disable iff (!rst_n)
    sync_found |-> (replay_active && out_valid && out_data == 8'hFF)); // R3

  AST_FOUND_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_found |=> !sync_found); // R4

endmodule

bind cfg_sync_aligner cfg_sync_aligner_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_ready      (in_ready),
  .out_valid     (out_valid),
  .out_data      (out_data),
  .out_last      (out_last),
  .out_ready     (out_ready),
  .sync_found    (sync_found),
  .no_sync_err   (no_sync_err),
  .search_active (search_active),
  .replay_active (replay_active),
  .pass_active   (pass_active)
);

// File: tb/cfg_sync_aligner_tb_top.sv
module cfg_sync_aligner_tb_top;

  localparam int OFS_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             mode_comp = 1'b0;
  logic             in_valid = 1'b0;
  logic [7:0]       in_data = '0;
  logic             in_last = 1'b0;
  logic             in_ready;
  logic             out_valid;
  logic [7:0]       out_data;
  logic             out_last;
  logic             out_ready = 1'b1;
  logic             sync_found;
  logic [OFS_W-1:0] sync_offset;
  logic             no_sync_err;

  always #5 clk = ~clk;

  cfg_sync_aligner #(.OFS_W(OFS_W)) dut_i (.*);

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int rdy_mode = 0;
  int found_cnt = 0;
  logic [8:0] exp_q[$];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // downstream ready pattern
  always @(negedge clk) begin
    cycles++;
    case (rdy_mode)
      1: out_ready = cycles[0];
      2: out_ready = (cycles % 3) != 0;
      default: out_ready = 1'b1;
    endcase
  end

  // monitor: one sample per cycle, 1 ns before the rising edge
  always begin
    @(negedge clk);
    #4;
    if (rst_n) begin
      if (sync_found) found_cnt++;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3/R7 unexpected byte", {out_last, out_data}, 0);
        end else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          check({out_last, out_data} == e, "R3 data/last", {out_last, out_data}, e);
        end
      end
    end
  end

  // reference: position of the first preamble, -1 if none
  function automatic int ref_offset(input logic [7:0] img[$], input bit comp);
    if (comp) begin
      for (int i = 0; i + 1 < img.size(); i++)
        if (img[i] == 8'hFF && img[i+1][7:4] == 4'h3) return i;
    end else begin
      for (int i = 0; i + 3 < img.size(); i++)
        if (img[i] == 8'hFF && img[i+1] == 8'hFF && img[i+2] == 8'hFF && img[i+3] == 8'hFF)
          return i;
    end
    return -1;
  endfunction

  task automatic push(input logic [7:0] b, input bit last);
    bit acc;
    in_valid = 1'b1;
    in_data  = b;
    in_last  = last;
    do begin
      #4 acc = in_ready;
      @(negedge clk);
    end while (!acc);
    in_valid = 1'b0;
  endtask

  task automatic run_image(input logic [7:0] img[$], input bit comp, input int gap,
                           input string req);
    int off;
    int wd;
    off = ref_offset(img, comp);
    mode_comp = comp;
    found_cnt = 0;
    if (off >= 0)
      for (int i = off; i < img.size(); i++)
        exp_q.push_back({(i == img.size() - 1), img[i]});
    for (int i = 0; i < img.size(); i++) begin
      push(img[i], i == img.size() - 1);
      for (int g = 0; g < gap; g++) @(negedge clk);
    end
    wd = 0;
    while (exp_q.size() != 0 && wd < 200) begin
      @(negedge clk);
      wd++;
    end
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, {req, " all bytes forwarded"}, exp_q.size(), 0);
    exp_q.delete();
    check(found_cnt == (off >= 0 ? 1 : 0), {req, " R4 found pulses"}, found_cnt, off >= 0);
    if (off >= 0)
      check(sync_offset == OFS_W'(off), {req, " R4 offset"}, sync_offset, off);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #4;
    check(!out_valid && in_ready && !no_sync_err && !sync_found, "R10 reset",
          {out_valid, in_ready, no_sync_err, sync_found}, 4'b0100);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 / R7: broken run of three, then a real run
    run_image('{8'h10, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'hFF, 8'hFF,
                8'hAA, 8'h55, 8'h3C}, 1'b0, 0, "R1/R7");
    check(!no_sync_err, "R6 no error yet", no_sync_err, 0);

    // R2 / R7: FF FF 3A, low nibble ignored, with back-pressure (R8)
    rdy_mode = 1;
    run_image('{8'h12, 8'h20, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'h3A, 8'h01, 8'h02, 8'h03},
              1'b1, 1, "R2/R7/R8");

    // R1: five FFs at offset 0, stalls every third cycle (R8)
    rdy_mode = 2;
    run_image('{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'h77}, 1'b0, 0, "R1/R8 offset0");

    // R5: preamble second byte is the last byte
    rdy_mode = 0;
    run_image('{8'h00, 8'hFF, 8'h4F, 8'hFF, 8'h3F}, 1'b1, 0, "R5 match at end");
    check(!no_sync_err, "R6 no error yet", no_sync_err, 0);

    // R5 / R6: lone trailing FF in compressed mode
    run_image('{8'h11, 8'h22, 8'hFF}, 1'b1, 0, "R5/R6 trailing FF");
    check(no_sync_err, "R6 error raised", no_sync_err, 1);

    // R1: compressed preamble does not count in uncompressed mode
    run_image('{8'hFF, 8'h30, 8'hFF, 8'hFF, 8'hFF, 8'h31}, 1'b0, 0, "R1 mode");

    // R2: four FFs without 0x3x do not count in compressed mode; R9 fresh search
    run_image('{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h20, 8'hFF, 8'h35, 8'h99}, 1'b1, 2, "R2/R9");
    check(no_sync_err, "R6 error sticky", no_sync_err, 1);

    // R9: consecutive images with different offsets
    run_image('{8'h01, 8'h02, 8'h03, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hEE}, 1'b0, 0, "R9 first");
    run_image('{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hEE}, 1'b0, 0, "R9 second");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule